// File: doc/BRIEF.md
# Rate One-Third Convolutional Encoder

This block turns a stream of message bits into a stream of 3-bit code symbols. It uses a fixed code with two memory bits and therefore four trellis states. Each accepted message bit yields one symbol. Each symbol bit is an exclusive-OR of the incoming bit with a fixed selection of the two stored bits. After the symbol is computed, the incoming bit is shifted into the memory. The block is used on the transmit side of a link, and it is also the stimulus generator for the self-checking bench of the matching decoder.

A terminate request closes a message. The encoder feeds two zero bits of its own into the trellis, emits the two symbols they produce, and ends in the all-zero state. That way the decoder's traceback has a known end point. The flush is run by a small controller with three named states:

- **PH_STREAM**: normal operation.
  - With a request and a data bit in the same cycle, it moves to **PH_TAIL2**. The data bit is encoded first.
  - With a request alone, it moves to **PH_TAIL1**. The first zero bit is encoded in that same cycle.
  - Otherwise it stays in **PH_STREAM**.
- **PH_TAIL2**: encodes a zero bit and always moves to **PH_TAIL1**.
- **PH_TAIL1**: encodes a zero bit and always returns to **PH_STREAM**.

While a tail phase is running, data strobes and terminate requests are ignored.

Top module: `conv3_encoder`

## Requirements
- R1: After synchronous reset, `state_out` is 00, `sym_valid` is 0 and `sym_out` is 000.
- R2: `sym_out[2]` equals the encoded bit XOR the newest stored bit (`state_out[1]` before the update), i.e. generator 110.
- R3: `sym_out[1]` equals the encoded bit XOR both stored bits, i.e. generator 111.
- R4: `sym_out[0]` equals the encoded bit XOR the oldest stored bit (`state_out[0]` before the update), i.e. generator 101.
- R5: When a bit is encoded, the state becomes {bit, old newest bit}. In a cycle with no encoded bit, the state holds.
- R6: `sym_valid` is high in exactly the cycle after an encoded bit. The symbol and the new state appear together in that cycle. With no data, no request and no tail running, `sym_valid` stays low.
- R7: A terminate request causes two zero bits to be encoded back to back, and after the second of them the state is 00. If the request comes without data, the zero bits are encoded in the request cycle and the next cycle.
- R8: Data strobes presented during the two tail cycles are ignored: neither the symbols nor the state depend on them.
- R9: A terminate request in the same cycle as a data bit encodes that bit first, and the two zero bits follow in the next two cycles.
- R10: A terminate request raised during the tail cycles is ignored. After the tail the encoder streams again, with no extra zero symbols.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| in_bit | input | 1 | Message bit |
| in_valid | input | 1 | Message bit strobe |
| term_req | input | 1 | Request to flush with two zero bits |
| sym_out | output | 3 | Code symbol: bit 2 from generator 110, bit 1 from 111, bit 0 from 101 |
| sym_valid | output | 1 | Symbol strobe, one cycle after the encoded bit |
| state_out | output | 2 | Trellis state: bit 1 is the newest stored bit, bit 0 the oldest |

## Verification
A data bit and a terminate request can arrive in the same cycle. A terminate request or a data strobe can also land inside a running tail. The bench drives both collisions on purpose: a request together with a data bit, then more data and more requests across the two tail cycles. Each symbol and state is compared against an arithmetic model. In that model the tail counter takes precedence, then data, then a bare request. An exhaustive sweep over all six-bit messages, started from a flushed state, and a long pseudo-random stream with sparse requests cover every state and input pair.

// File: rtl/conv3_pkg.sv
package conv3_pkg;

    localparam int MEM_BITS = 2;
    localparam int NUM_OUT  = 3;
    localparam int TAP_W    = MEM_BITS + 1;

    // Tap vector order is {input, newest, oldest}; index NUM_OUT-1 is the first symbol bit.
    localparam logic [NUM_OUT-1:0][TAP_W-1:0] GEN_TAPS = {3'b110, 3'b111, 3'b101};

    typedef enum logic [1:0] {
        PH_STREAM = 2'd0,
        PH_TAIL2  = 2'd1,
        PH_TAIL1  = 2'd2
    } phase_e;

endpackage

// File: rtl/conv3_trellis.sv
module conv3_trellis
    import conv3_pkg::*;
(
    input  logic [MEM_BITS-1:0] cur_state,
    input  logic                in_bit,
    output logic [NUM_OUT-1:0]  sym_next,
    output logic [MEM_BITS-1:0] state_next
);

    logic [TAP_W-1:0] taps;
    assign taps = {in_bit, cur_state};

    for (genvar j = 0; j < NUM_OUT; j++) begin : g_out
        assign sym_next[j] = ^(GEN_TAPS[j] & taps);
    end

    assign state_next = {in_bit, cur_state[MEM_BITS-1:1]};

endmodule

// File: rtl/conv3_flush_ctrl.sv
module conv3_flush_ctrl
    import conv3_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   in_valid,
    input  logic   in_bit,
    input  logic   term_req,
    output logic   enc_valid,
    output logic   enc_bit,
    output phase_e phase
);

    phase_e phase_q, phase_d;

    always_ff @(posedge clk) begin
        if (rst) phase_q <= PH_STREAM;
        else     phase_q <= phase_d;
    end

    always_comb begin
        phase_d   = phase_q;
        enc_valid = 1'b0;
        enc_bit   = 1'b0;
        unique case (phase_q)
            PH_STREAM: begin
                enc_valid = in_valid | term_req;
                enc_bit   = in_valid & in_bit;
                if (term_req) phase_d = in_valid ? PH_TAIL2 : PH_TAIL1;
            end
            PH_TAIL2: begin
                enc_valid = 1'b1;
                phase_d   = PH_TAIL1;
            end
            PH_TAIL1: begin
                enc_valid = 1'b1;
                phase_d   = PH_STREAM;
            end
            default: phase_d = PH_STREAM;
        endcase
    end

    assign phase = phase_q;

    assert_tail_order_R10: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_TAIL2) |=> (phase_q == PH_TAIL1));

    assert_tail_exit_R7: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_TAIL1) |=> (phase_q == PH_STREAM));

endmodule

// File: rtl/conv3_encoder.sv
module conv3_encoder
    import conv3_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                in_bit,
    input  logic                in_valid,
    input  logic                term_req,
    output logic [NUM_OUT-1:0]  sym_out,
    output logic                sym_valid,
    output logic [MEM_BITS-1:0] state_out
);

    logic                enc_valid;
    logic                enc_bit;
    phase_e              phase;
    logic [NUM_OUT-1:0]  sym_next;
    logic [MEM_BITS-1:0] state_next;
    logic [MEM_BITS-1:0] state_q;
    logic [NUM_OUT-1:0]  sym_q;
    logic                valid_q;

    conv3_flush_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_bit    (in_bit),
        .term_req  (term_req),
        .enc_valid (enc_valid),
        .enc_bit   (enc_bit),
        .phase     (phase)
    );

    conv3_trellis u_trellis (
        .cur_state  (state_q),
        .in_bit     (enc_bit),
        .sym_next   (sym_next),
        .state_next (state_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
            sym_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= enc_valid;
            if (enc_valid) begin
                state_q <= state_next;
                sym_q   <= sym_next;
            end
        end
    end

    assign sym_out   = sym_q;
    assign sym_valid = valid_q;
    assign state_out = state_q;

    assert_flush_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_TAIL1) |=> (state_q == '0 && valid_q));

    assert_hold_idle_R5: assert property (@(posedge clk) disable iff (rst)
        (!enc_valid) |=> ($stable(state_q) && !valid_q));

    assert_shift_R5: assert property (@(posedge clk) disable iff (rst)
        enc_valid |=> (state_q[MEM_BITS-1] == $past(enc_bit)
                       && state_q[0] == $past(state_q[1])));

    assert_strobe_R6: assert property (@(posedge clk) disable iff (rst)
        enc_valid |=> valid_q);

    assert_parity_R3: assert property (@(posedge clk) disable iff (rst)
        valid_q |-> (sym_q[1] == (sym_q[2] ^ sym_q[0] ^ state_q[1])));

endmodule

// File: tb/conv3_encoder_test.sv
module conv3_encoder_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_bit = 1'b0;
    logic       in_valid = 1'b0;
    logic       term_req = 1'b0;
    logic [2:0] sym_out;
    logic       sym_valid;
    logic [1:0] state_out;

    int checks = 0;
    int errors = 0;

    logic [1:0] exp_state = 2'b00;
    int         tail_left = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    conv3_encoder uut (
        .clk       (clk),
        .rst       (rst),
        .in_bit    (in_bit),
        .in_valid  (in_valid),
        .term_req  (term_req),
        .sym_out   (sym_out),
        .sym_valid (sym_valid),
        .state_out (state_out)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One cycle: drive on the falling edge, check just after the rising edge.
    task automatic step(input logic v, input logic b, input logic t, input string ctx);
        logic ev, eb, n, o;
        ev = 1'b0; eb = 1'b0;
        @(negedge clk);
        in_valid = v; in_bit = b; term_req = t;
        @(posedge clk);
        #1;
        n = exp_state[1]; o = exp_state[0];
        if (tail_left > 0) begin
            ev = 1'b1; tail_left--;
        end else if (v) begin
            ev = 1'b1; eb = b;
            if (t) tail_left = 2;
        end else if (t) begin
            ev = 1'b1; tail_left = 1;
        end
        chk({ctx, " R6 valid"}, int'(sym_valid), int'(ev));
        if (ev) begin
            chk("R2 sym bit2", int'(sym_out[2]), int'(eb ^ n));
            chk("R3 sym bit1", int'(sym_out[1]), int'(eb ^ n ^ o));
            chk("R4 sym bit0", int'(sym_out[0]), int'(eb ^ o));
            exp_state = {eb, n};
        end
        chk({ctx, " R5 state"}, int'(state_out), int'(exp_state));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL R6 watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 reset state", int'(state_out), 0);
        chk("R1 reset valid", int'(sym_valid), 0);
        chk("R1 reset symbol", int'(sym_out), 0);

        // Exhaustive six-bit messages, each from a flushed trellis (R7 bare request).
        for (int p = 0; p < 64; p++) begin
            step(1'b0, 1'b0, 1'b1, "R7 bare request");
            step(1'b0, 1'b0, 1'b0, "R7 second tail");
            chk("R7 flushed state", int'(state_out), 0);
            for (int i = 0; i < 6; i++) begin
                step(1'b1, p[i], 1'b0, "R5 stream");
                if (p[0] && i == 2) step(1'b0, 1'b1, 1'b0, "R6 gap");
            end
        end

        // R9: data and request together, then R8 data inside the tail.
        step(1'b1, 1'b1, 1'b0, "R5 prefill");
        step(1'b1, 1'b1, 1'b1, "R9 data with request");
        chk("R9 data bit encoded first", int'(state_out), 3);
        step(1'b1, 1'b1, 1'b0, "R8 data in tail A");
        step(1'b1, 1'b1, 1'b0, "R8 data in tail B");
        chk("R8 state after tail", int'(state_out), 0);

        // R10: request inside the tail is ignored, streaming resumes.
        step(1'b1, 1'b1, 1'b1, "R9 data with request");
        step(1'b0, 1'b0, 1'b1, "R10 request in tail A");
        step(1'b1, 1'b0, 1'b1, "R10 request in tail B");
        chk("R10 state after tail", int'(state_out), 0);
        step(1'b1, 1'b1, 1'b0, "R10 stream resumes");
        chk("R10 no extra tail", int'(state_out), 2);
        step(1'b0, 1'b0, 1'b0, "R6 idle");

        // Pseudo-random stream with sparse requests.
        begin
            logic [15:0] lfsr;
            lfsr = 16'hACE1;
            for (int k = 0; k < 2000; k++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                step(lfsr[0] | lfsr[1], lfsr[2], (lfsr[7:4] == 4'hF), "R5 random");
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule